// File: doc/BRIEF.md
# Transmit Pad and FCS Appender

This block sits in the transmit path ahead of the MAC and works on a byte stream with valid/ready flow control. Each input beat carries one data byte, an end-of-frame flag, an abort flag and a per-frame no-CRC request. The no-CRC request is looked at only on the opening beat of a frame. For an ordinary frame the block forwards the payload and zero-fills it up to the data length that gives a 64-byte frame with its checksum. It then appends the 32-bit Ethernet frame check sequence. When the no-CRC request is set, the bytes pass through untouched, because the payload is taken to hold its own checksum already.

If a frame is cut short by an abort, the block must not let a valid-looking frame reach the wire. The aborting beat is forwarded as the last payload byte, no padding follows, and four checksum bytes are appended that are the bitwise inverse of the correct value for the bytes actually sent. Padding and checksum bytes are generated from internal state, so the input is stalled while they go out.

Top module: `txfcs_append`

## Requirements
- R1: With no-CRC clear, a frame of 60 or more payload bytes comes out as the payload unchanged, followed by four checksum bytes, least significant byte first. The checksum is CRC-32 (polynomial 0x04C11DB7 in reflected form 0xEDB88320, seed 0xFFFFFFFF, result complemented) over every byte sent before it.
- R2: With no-CRC clear, a frame of fewer than 60 payload bytes is followed by 0x00 bytes up to 60 bytes in total. The checksum covers those pad bytes. A frame of exactly 60 bytes gets no padding.
- R3: With no-CRC set, the frame comes out byte for byte as it went in, with no padding and no checksum, and with out_last on the final payload byte.
- R4: in_nocrc is sampled only on the first beat of a frame. Its value on every later beat of that frame has no effect on the output.
- R5: A beat accepted with in_abort set ends the frame. Its byte is forwarded, no padding is added, and the four appended bytes, least significant first, equal the bitwise inverse of the correct R1 checksum of the bytes sent. This applies whatever the no-CRC setting.
- R6: out_last is high only on the final byte of each output frame: the last checksum byte, or the last payload byte of an unaborted no-CRC frame.
- R7: While out_valid is high and out_ready is low, out_data and out_last hold their values. in_ready stays low while pad or checksum bytes are being emitted, and no byte is lost or repeated under backpressure.
- R8: Frames of up to 16384 payload bytes are handled with no truncation and with a correct checksum.
- R9: After reset, out_valid is low while no input is offered, in_ready follows out_ready, and the first accepted beat starts a new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat accepted this cycle when also valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Final beat of the frame |
| in_abort | input | 1 | Frame aborted at this beat |
| in_nocrc | input | 1 | No padding and no checksum; used on the first beat only |
| out_valid | output | 1 | Output byte offered |
| out_ready | input | 1 | Sink accepts the output byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the output frame |

## Verification
The bench uses the default parameters: a 64-byte minimum frame and a 4-byte checksum. This puts the pad boundary at 60 payload bytes and tests 59, 60 and 61 directly. At these values a 16384-byte frame runs in a modest number of cycles, so the full-length case is exercised in one pass. The pad counter's saturation on long frames is covered in that same run. Random output stalls land inside payload, pad and checksum phases, which tests both the hold rules and the input stall during the generated tail.

// File: rtl/txfcs_pkg.sv
package txfcs_pkg;

  typedef enum logic [1:0] {
    ST_DATA = 2'd0,
    ST_PAD  = 2'd1,
    ST_FCS  = 2'd2
  } tx_state_e;

  // CRC-32, polynomial 0x04C11DB7 processed LSB first (reflected form).
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED      = 32'hFFFFFFFF;

  function automatic logic [31:0] crc32_byte(input logic [31:0] c_in,
                                             input logic [7:0]  d);
    logic [31:0] c;
    c = c_in;
    for (int b = 0; b < 8; b++) begin
      if (c[0] ^ d[b]) c = (c >> 1) ^ CRC_POLY_REFL;
      else             c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/txfcs_crc.sv
module txfcs_crc
  import txfcs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc_o
);

  logic [31:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (clr)     crc_d = CRC_SEED;
    else if (en) crc_d = crc32_byte(crc_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          crc_q <= CRC_SEED;
    else if (clr || en)  crc_q <= crc_d;
  end

  assign crc_o = crc_q;

  // R1: every new frame starts from the seed
  a_r1_seed_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc_o == CRC_SEED));

endmodule

// File: rtl/txfcs_len.sv
module txfcs_len #(
  parameter int PAD_BYTES = 60,
  localparam int CW       = $clog2(PAD_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt_o
);

  localparam logic [CW-1:0] CAP = CW'(PAD_BYTES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // Saturates at the pad length: long frames only need "already long enough".
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = clr || (inc && (cnt_q != CAP));
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R8: counter never wraps on long frames
  a_r8_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o <= CAP);

  // R2: clear returns the frame length to zero
  a_r2_cnt_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_o == '0));

endmodule

// File: rtl/txfcs_ctrl.sv
module txfcs_ctrl
  import txfcs_pkg::*;
#(
  parameter int PAD_BYTES = 60,
  parameter int FCS_BYTES = 4,
  localparam int CW       = $clog2(PAD_BYTES + 1),
  localparam int IW       = $clog2(FCS_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  input  logic          in_abort,
  input  logic          in_nocrc,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic          out_last,
  input  logic [CW-1:0] cnt_i,
  input  logic [31:0]   crc_i,
  output logic          crc_clr,
  output logic          crc_en,
  output logic [7:0]    crc_din,
  output logic          len_clr,
  output logic          len_inc
);

  localparam logic [CW-1:0] PAD_LAST = CW'(PAD_BYTES - 1);
  localparam logic [IW-1:0] IDX_LAST = IW'(FCS_BYTES - 1);

  tx_state_e     state_q, state_d;
  logic          sof_q, sof_d;
  logic          nocrc_q, nocrc_d;
  logic          bad_q, bad_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          nocrc_eff;
  logic [31:0]   fcs_word;
  logic [7:0]    fcs_byte;
  logic          reg_en;

  assign nocrc_eff = sof_q ? in_nocrc : nocrc_q;
  assign fcs_word  = bad_q ? crc_i : ~crc_i;
  assign fcs_byte  = fcs_word[{idx_q, 3'b000} +: 8];

  always_comb begin
    state_d   = state_q;
    sof_d     = sof_q;
    nocrc_d   = nocrc_q;
    bad_d     = bad_q;
    idx_d     = idx_q;
    out_valid = 1'b0;
    out_data  = 8'h00;
    out_last  = 1'b0;
    in_ready  = 1'b0;
    crc_clr   = 1'b0;
    crc_en    = 1'b0;
    crc_din   = 8'h00;
    len_clr   = 1'b0;
    len_inc   = 1'b0;
    unique case (state_q)
      ST_DATA: begin
        out_valid = in_valid;
        out_data  = in_data;
        out_last  = in_valid && in_last && nocrc_eff && !in_abort;
        in_ready  = out_ready;
        if (in_valid && out_ready) begin
          crc_en  = 1'b1;
          crc_din = in_data;
          len_inc = 1'b1;
          sof_d   = 1'b0;
          nocrc_d = nocrc_eff;
          if (in_abort) begin
            state_d = ST_FCS;
            bad_d   = 1'b1;
          end else if (in_last) begin
            bad_d = 1'b0;
            if (nocrc_eff) begin
              sof_d   = 1'b1;
              crc_clr = 1'b1;
              len_clr = 1'b1;
            end else if (cnt_i >= PAD_LAST) begin
              state_d = ST_FCS;
            end else begin
              state_d = ST_PAD;
            end
          end
        end
      end
      ST_PAD: begin
        out_valid = 1'b1;
        if (out_ready) begin
          crc_en  = 1'b1;
          len_inc = 1'b1;
          if (cnt_i >= PAD_LAST) state_d = ST_FCS;
        end
      end
      ST_FCS: begin
        out_valid = 1'b1;
        out_data  = fcs_byte;
        out_last  = (idx_q == IDX_LAST);
        if (out_ready) begin
          idx_d = idx_q + IW'(1);
          if (idx_q == IDX_LAST) begin
            idx_d   = '0;
            state_d = ST_DATA;
            sof_d   = 1'b1;
            bad_d   = 1'b0;
            crc_clr = 1'b1;
            len_clr = 1'b1;
          end
        end
      end
      default: begin
        state_d = ST_DATA;
        sof_d   = 1'b1;
      end
    endcase
  end

  assign reg_en = out_ready || (state_q != ST_DATA && state_q != ST_PAD && state_q != ST_FCS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_DATA;
      sof_q   <= 1'b1;
      nocrc_q <= 1'b0;
      bad_q   <= 1'b0;
      idx_q   <= '0;
    end else if (reg_en) begin
      state_q <= state_d;
      sof_q   <= sof_d;
      nocrc_q <= nocrc_d;
      bad_q   <= bad_d;
      idx_q   <= idx_d;
    end
  end

  // R7: generated bytes block the input
  a_r7_tail_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_DATA) |-> !in_ready);

  // R7: generated bytes hold under backpressure
  a_r7_tail_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && state_q != ST_DATA)
      |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R2: padding only while the frame is shorter than the pad length
  a_r2_pad_short_only: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PAD) |-> (cnt_i <= PAD_LAST));

  // R5: all checksum bytes follow once started
  a_r5_fcs_runs_out: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FCS && out_ready && idx_q != IDX_LAST) |=> (state_q == ST_FCS));

  // R6: frame end marker only on the closing byte
  a_r6_last_closing: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last && state_q == ST_FCS) |-> (idx_q == IDX_LAST));

endmodule

// File: rtl/txfcs_append.sv
module txfcs_append #(
  parameter int MIN_FRAME = 64,
  parameter int FCS_BYTES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_last,
  input  logic       in_abort,
  input  logic       in_nocrc,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_last
);

  localparam int PAD_BYTES = MIN_FRAME - FCS_BYTES;
  localparam int CW        = $clog2(PAD_BYTES + 1);

  logic [CW-1:0] cnt;
  logic [31:0]   crc;
  logic          crc_clr, crc_en, len_clr, len_inc;
  logic [7:0]    crc_din;

  txfcs_ctrl #(
    .PAD_BYTES (PAD_BYTES),
    .FCS_BYTES (FCS_BYTES)
  ) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_last   (in_last),
    .in_abort  (in_abort),
    .in_nocrc  (in_nocrc),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last),
    .cnt_i     (cnt),
    .crc_i     (crc),
    .crc_clr   (crc_clr),
    .crc_en    (crc_en),
    .crc_din   (crc_din),
    .len_clr   (len_clr),
    .len_inc   (len_inc)
  );

  txfcs_crc crc_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (crc_clr),
    .en    (crc_en),
    .din   (crc_din),
    .crc_o (crc)
  );

  txfcs_len #(
    .PAD_BYTES (PAD_BYTES)
  ) len_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (len_clr),
    .inc   (len_inc),
    .cnt_o (cnt)
  );

  // R6: end marker never without a byte
  a_r6_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

endmodule

// File: tb/txfcs_append_tb_top.sv
module txfcs_append_tb_top;

  logic       clk;
  logic       rst_n;
  logic       in_valid, in_ready, in_last, in_abort, in_nocrc;
  logic [7:0] in_data;
  logic       out_valid, out_ready, out_last;
  logic [7:0] out_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit stall_on = 1'b0;
  bit done = 1'b0;

  logic [9:0] exp_q[$];   // {tail, last, data}
  string      tag_q[$];

  logic       prev_stall = 1'b0;
  logic [7:0] prev_data  = 8'h00;
  logic       prev_last  = 1'b0;

  txfcs_append dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_last   (in_last),
    .in_abort  (in_abort),
    .in_nocrc  (in_nocrc),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] ref_crc(input logic [31:0] c_in, input logic [7:0] d);
    logic [31:0] c;
    c = c_in;
    for (int b = 0; b < 8; b++) begin
      if (c[0] ^ d[b]) c = (c >> 1) ^ 32'hEDB88320;
      else             c = c >> 1;
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) out_ready = stall_on ? (($urandom % 4) != 0) : 1'b1;

  // Reference comparison on every cycle
  always @(negedge clk) begin
    #3;
    if (rst_n) begin
      if (prev_stall)
        check(out_valid && out_data == prev_data && out_last == prev_last,
              "R7", "hold under stall", {23'd0, out_valid, out_data}, {23'd0, 1'b1, prev_data});
      if (exp_q.size() != 0 && exp_q[0][9])
        check(!in_ready, "R7", "input blocked during tail", {31'd0, in_ready}, 32'd0);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6", "unexpected output byte", {24'd0, out_data}, 32'd0);
        end else begin
          logic [9:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_data == e[7:0] && out_last == e[8], t, "output byte/last",
                {23'd0, out_last, out_data}, {23'd0, e[8], e[7:0]});
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      prev_last  = out_last;
    end
  end

  task automatic send_frame(input int len, input bit nc_first, input bit nc_rest,
                            input int abort_at, input string tag);
    logic [7:0]  bytes[$];
    logic [31:0] c, fcs;
    int          n;
    bit          ok;
    c = 32'hFFFFFFFF;
    n = (abort_at >= 0) ? abort_at + 1 : len;
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      bytes.push_back(b);
      c = ref_crc(c, b);
      exp_q.push_back({1'b0, (abort_at < 0 && nc_first && i == n - 1), b});
      tag_q.push_back(tag);
    end
    fcs = 32'd0;
    if (abort_at >= 0) begin
      fcs = c;
    end else if (!nc_first) begin
      for (int k = n; k < 60; k++) begin
        c = ref_crc(c, 8'h00);
        exp_q.push_back({1'b1, 1'b0, 8'h00});
        tag_q.push_back(tag);
      end
      fcs = ~c;
    end
    if (abort_at >= 0 || !nc_first)
      for (int k = 0; k < 4; k++) begin
        exp_q.push_back({1'b1, (k == 3), fcs[8*k +: 8]});
        tag_q.push_back(tag);
      end
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1;
      in_data  = bytes[i];
      in_last  = (abort_at < 0) && (i == n - 1);
      in_abort = (abort_at >= 0) && (i == n - 1);
      in_nocrc = (i == 0) ? nc_first : nc_rest;
      forever begin
        #1;
        ok = in_ready;
        @(negedge clk);
        if (ok) break;
      end
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    in_abort = 1'b0;
    in_nocrc = 1'b0;
  endtask

  task automatic drain(input string tag);
    int w;
    w = 0;
    while (exp_q.size() != 0 && w < 2000) begin
      @(negedge clk);
      w++;
    end
    check(exp_q.size() == 0, tag, "frame fully emitted", exp_q.size(), 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = 8'h00;
    in_last  = 1'b0;
    in_abort = 1'b0;
    in_nocrc = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    // R9: idle after reset
    check(!out_valid, "R9", "out_valid idle after reset", {31'd0, out_valid}, 32'd0);
    check(in_ready == out_ready, "R9", "in_ready follows out_ready", {31'd0, in_ready}, {31'd0, out_ready});
    @(negedge clk);

    send_frame(64, 1'b0, 1'b0, -1, "R1");  drain("R1");
    send_frame(100, 1'b0, 1'b0, -1, "R1"); drain("R1");
    send_frame(1, 1'b0, 1'b0, -1, "R2");   drain("R2");
    send_frame(10, 1'b0, 1'b0, -1, "R2");  drain("R2");
    send_frame(59, 1'b0, 1'b0, -1, "R2");  drain("R2");
    send_frame(60, 1'b0, 1'b0, -1, "R2");  drain("R2");
    send_frame(61, 1'b0, 1'b0, -1, "R2");  drain("R2");
    send_frame(64, 1'b1, 1'b1, -1, "R3");  drain("R3");
    send_frame(5, 1'b1, 1'b1, -1, "R3");   drain("R3");
    send_frame(20, 1'b1, 1'b0, -1, "R4");  drain("R4");
    send_frame(20, 1'b0, 1'b1, -1, "R4");  drain("R4");
    send_frame(100, 1'b0, 1'b0, 10, "R5"); drain("R5");
    send_frame(100, 1'b0, 1'b0, 0, "R5");  drain("R5");
    send_frame(100, 1'b1, 1'b1, 70, "R5"); drain("R5");

    stall_on = 1'b1;
    send_frame(3, 1'b0, 1'b0, -1, "R7");   drain("R7");
    send_frame(75, 1'b0, 1'b1, -1, "R7");  drain("R7");
    send_frame(30, 1'b1, 1'b0, -1, "R6");  drain("R6");
    send_frame(40, 1'b0, 1'b0, 25, "R5");  drain("R5");
    send_frame(12, 1'b1, 1'b1, 6, "R5");   drain("R5");
    for (int f = 0; f < 8; f++) begin
      send_frame(1 + ($urandom % 90), f[0], f[1], -1, "R6");
      drain("R6");
    end
    stall_on = 1'b0;

    send_frame(16384, 1'b0, 1'b0, -1, "R8"); drain("R8");

    repeat (4) @(negedge clk);
    check(!out_valid, "R6", "idle after final frame", {31'd0, out_valid}, 32'd0);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule